// File: doc/BRIEF.md
# Multi-Mode 8-Bit Timer with Capture and PWM

This block is an 8-bit up-counter with one control register and one data register. The control register sets four things: the operating mode, the tick source, the interrupt enables, and the write-to-clear match flag. The tick source is one of three power-of-two divisions of the system clock, or the rising edges of an external clock pin.

In interval mode the counter counts up to the data register value, restarts, and toggles the output pin. In the two capture modes the data register stores the counter value on a chosen edge of the capture pin. In PWM mode the output pin is high while the counter is below the data register value.

Two interrupt request lines leave the block: overflow and match/capture. The overflow request is cleared by an acknowledge pulse, which stands in for the interrupt being serviced. The match/capture request is cleared by software, which writes zero to the pending bit.

Top module: `tmr8_multimode`

## Requirements
- R1: After reset the control register reads 8'h00 (interval mode, clock select 00 = system clock / 1024, both interrupts disabled), the counter reads 0, the timer output is low and both interrupt lines are low.
- R2: The counter changes only by advancing one step per selected tick, by a match restart, or by a clear command. From FF it wraps to 00.
- R3: In interval mode (mode 00), a tick while the counter equals the data register does three things: it returns the counter to 0, it toggles the timer output, and it sets the match/capture pending bit (control bit 0).
- R4: In PWM mode (mode 11) the counter runs freely. The timer output is high exactly while the counter is below the data register, so a data value of 0 keeps the output low.
- R5: Writing the control register with bit 3 set clears the counter and restarts the prescaler. Bit 3 always reads 0, and writing 0 to it has no effect.
- R6: Clock select is control bits [5:4]: 00 = one tick per 1024 system clocks, 01 = per 256, 10 = per 64, 11 = per rising edge of the external clock pin. The external pin passes through a two-flip-flop synchroniser first.
- R7: A tick at counter FF that does not cause an interval match sets overflow pending. This includes both capture modes and PWM mode. `irq_ovf` is pending AND enable (control bit 2). An `ovf_ack` pulse clears pending.
- R8: `irq_match` is the pending bit AND the enable (control bit 1). Writing the control register with bit 0 = 0 clears the pending bit. Writing bit 0 = 1 does not set it.
- R9: In mode 01, a rising edge of the synchronised capture pin copies the counter into the data register and sets the pending bit. Falling edges are ignored.
- R10: In mode 10, a falling edge of the synchronised capture pin captures. Rising edges are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 control, 1 data, 2 counter (read only) |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register (combinational) |
| cap_in | input | 1 | Capture pin, asynchronous |
| ext_clk | input | 1 | External count clock, asynchronous |
| ovf_ack | input | 1 | Overflow service acknowledge pulse |
| tmr_out | output | 1 | Interval toggle or PWM waveform |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_match | output | 1 | Match/capture interrupt request |

## Verification
The assertions assume that reset is held low at the start, so every `$past` term refers to a value written after reset. They also assume that bus writes are single-cycle strobes, and that `ovf_ack` is not raised in a cycle where the counter sits at FF with a tick pending. The stimulus satisfies these assumptions in three ways. It drives every input at the falling clock edge. It holds each level of the external clock and capture pins for at least three system clocks, so the synchroniser sees each edge exactly once. It pulses the acknowledge only after the counter has already wrapped to 00.

// File: rtl/tmr8_pkg.sv
// Shared types for the multi-mode timer.
// Assumes: the mode code and register-select code widths are fixed at 2 bits.
package tmr8_pkg;
    typedef enum logic [1:0] {
        MODE_INTERVAL = 2'b00,
        MODE_CAP_RISE = 2'b01,
        MODE_CAP_FALL = 2'b10,
        MODE_PWM      = 2'b11
    } tmr_mode_e;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'b00,
        SEL_DATA  = 2'b01,
        SEL_COUNT = 2'b10,
        SEL_NONE  = 2'b11
    } reg_sel_e;
endpackage

// File: rtl/tmr8_sync_edge.sv
// Synchroniser for an asynchronous pin with single-cycle edge strobes.
// Assumes: the pin holds each level for longer than STAGES+1 clocks.
module tmr8_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] sh_q;

    // Shift the pin through the synchroniser plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], din};
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/tmr8_prescaler.sv
// Free-running prescaler and tick-source selector.
// Assumes: divisors are powers of two given as log2, and DIV0_LOG is the largest.
module tmr8_prescaler #(
    parameter int DIV0_LOG = 10,
    parameter int DIV1_LOG = 8,
    parameter int DIV2_LOG = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [1:0] clk_sel,
    input  logic       ext_rise,
    output logic       tick
);
    localparam int PRE_W = DIV0_LOG;

    logic [PRE_W-1:0] pre_q;
    logic [2:0]       tap;

    // Count system clocks; a counter clear restarts the division.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) pre_q <= '0;
        else                   pre_q <= pre_q + 1'b1;
    end

    for (genvar i = 0; i < 3; i++) begin : g_tap
        localparam int L = (i == 0) ? DIV0_LOG : (i == 1) ? DIV1_LOG : DIV2_LOG;
        assign tap[i] = &pre_q[L-1:0];
    end

    // Pick the tick source named by the clock select field.
    always_comb begin
        case (clk_sel)
            2'b00:   tick = tap[0];
            2'b01:   tick = tap[1];
            2'b10:   tick = tap[2];
            default: tick = ext_rise;
        endcase
    end
endmodule

// File: rtl/tmr8_core.sv
// Counter, data register and output waveform for the timer.
// Assumes: tick and cap_strobe are single-cycle; clr has priority over tick.
module tmr8_core
    import tmr8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  tmr_mode_e    mode,
    input  logic         tick,
    input  logic         clr,
    input  logic         cap_strobe,
    input  logic         data_wr,
    input  logic [W-1:0] data_wdata,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] data_q,
    output logic         out,
    output logic         match_evt,
    output logic         ovf_evt
);
    logic ivl_match;
    logic tgl_q;

    assign ivl_match = tick && (mode == MODE_INTERVAL) && (cnt_q == data_q);
    assign ovf_evt   = tick && (&cnt_q) && !ivl_match;
    assign match_evt = ivl_match || cap_strobe;

    // Counter: clear, restart on interval match, otherwise step on tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else if (ivl_match) cnt_q <= '0;
        else if (tick)      cnt_q <= cnt_q + 1'b1;
    end

    // Data register: a capture wins over a bus write in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)         data_q <= '0;
        else if (cap_strobe) data_q <= cnt_q;
        else if (data_wr)    data_q <= data_wdata;
    end

    // Interval toggle flop.
    always_ff @(posedge clk) begin
        if (!rst_n)        tgl_q <= 1'b0;
        else if (ivl_match) tgl_q <= ~tgl_q;
    end

    // Output waveform per mode.
    always_comb begin
        case (mode)
            MODE_INTERVAL: out = tgl_q;
            MODE_PWM:      out = (cnt_q < data_q);
            default:       out = 1'b0;
        endcase
    end
endmodule

// File: rtl/tmr8_multimode.sv
// Top of the multi-mode timer: control register, register bus and interrupts.
// Assumes: single-cycle write strobes; asynchronous pins are synchronised here.
module tmr8_multimode
    import tmr8_pkg::*;
#(
    parameter int W        = 8,
    parameter int SYNC_STG = 2,
    parameter int DIV0_LOG = 10,
    parameter int DIV1_LOG = 8,
    parameter int DIV2_LOG = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   reg_sel,
    input  logic         wr_en,
    input  logic [7:0]   wr_data,
    output logic [7:0]   rd_data,
    input  logic         cap_in,
    input  logic         ext_clk,
    input  logic         ovf_ack,
    output logic         tmr_out,
    output logic         irq_ovf,
    output logic         irq_match
);
    tmr_mode_e   mode_q;
    logic [1:0]  clksel_q;
    logic        ovf_ie_q, mc_ie_q, mc_pend_q, ovf_pend_q;
    logic        ctrl_wr, clr, tick, ext_rise, cap_rise, cap_fall, cap_strobe;
    logic        match_evt, ovf_evt;
    logic [W-1:0] cnt_q, data_q;

    assign ctrl_wr = wr_en && (reg_sel == SEL_CTRL);
    assign clr     = ctrl_wr && wr_data[3];

    tmr8_sync_edge #(.STAGES(SYNC_STG)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .din(ext_clk), .rise(ext_rise), .fall()
    );

    tmr8_sync_edge #(.STAGES(SYNC_STG)) u_cap_sync (
        .clk(clk), .rst_n(rst_n), .din(cap_in), .rise(cap_rise), .fall(cap_fall)
    );

    tmr8_prescaler #(.DIV0_LOG(DIV0_LOG), .DIV1_LOG(DIV1_LOG), .DIV2_LOG(DIV2_LOG)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart(clr), .clk_sel(clksel_q),
        .ext_rise(ext_rise), .tick(tick)
    );

    assign cap_strobe = ((mode_q == MODE_CAP_RISE) && cap_rise) ||
                        ((mode_q == MODE_CAP_FALL) && cap_fall);

    tmr8_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .mode(mode_q), .tick(tick), .clr(clr),
        .cap_strobe(cap_strobe), .data_wr(wr_en && (reg_sel == SEL_DATA)),
        .data_wdata(wr_data[W-1:0]), .cnt_q(cnt_q), .data_q(data_q),
        .out(tmr_out), .match_evt(match_evt), .ovf_evt(ovf_evt)
    );

    // Stored control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MODE_INTERVAL;
            clksel_q <= 2'b00;
            ovf_ie_q <= 1'b0;
            mc_ie_q  <= 1'b0;
        end else if (ctrl_wr) begin
            mode_q   <= tmr_mode_e'(wr_data[7:6]);
            clksel_q <= wr_data[5:4];
            ovf_ie_q <= wr_data[2];
            mc_ie_q  <= wr_data[1];
        end
    end

    // Match/capture pending: set by hardware, cleared by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                       mc_pend_q <= 1'b0;
        else if (match_evt)               mc_pend_q <= 1'b1;
        else if (ctrl_wr && !wr_data[0])  mc_pend_q <= 1'b0;
    end

    // Overflow pending: set on rollover, cleared by service acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_pend_q <= 1'b0;
        else if (ovf_evt) ovf_pend_q <= 1'b1;
        else if (ovf_ack) ovf_pend_q <= 1'b0;
    end

    assign irq_ovf   = ovf_pend_q && ovf_ie_q;
    assign irq_match = mc_pend_q && mc_ie_q;

    // Register read mux; the clear command bit reads as 0.
    always_comb begin
        case (reg_sel)
            SEL_CTRL:  rd_data = {mode_q, clksel_q, 1'b0, ovf_ie_q, mc_ie_q, mc_pend_q};
            SEL_DATA:  rd_data = 8'(data_q);
            SEL_COUNT: rd_data = 8'(cnt_q);
            default:   rd_data = 8'h00;
        endcase
    end
endmodule

// File: rtl/tmr8_checker.sv
// Property checker for the multi-mode timer, bound to the top module.
// Assumes: reset is asserted from time zero.
module tmr8_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] reg_sel,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       ovf_ack,
    input logic       tmr_out,
    input logic       irq_ovf,
    input logic [1:0] mode,
    input logic [7:0] cnt,
    input logic [7:0] data_q
);
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 8'd1 || cnt == 8'd0)); // R2

    AST_TOGGLE_AT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && $past(mode) == 2'b00 && tmr_out != $past(tmr_out)) |-> cnt == 8'd0); // R3

    AST_PWM_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11 && data_q == 8'd0) |-> !tmr_out); // R4

    AST_CLEAR_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == 2'b00 && wr_data[3]) |=> cnt == 8'd0); // R5

    AST_OVF_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_ack && cnt != 8'hFF) |=> !irq_ovf); // R7
endmodule

bind tmr8_multimode tmr8_checker u_chk (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data),
    .ovf_ack(ovf_ack), .tmr_out(tmr_out), .irq_ovf(irq_ovf),
    .mode(mode_q), .cnt(cnt_q), .data_q(data_q)
);

// File: tb/sim_tmr8_multimode.sv
// Self-checking bench for the multi-mode timer.
module sim_tmr8_multimode;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    // PWM table: {data, ext pulses after clear, expected tmr_out}
    localparam logic [16:0] PWM_TBL [7] = '{
        {8'h80, 8'h10, 1'b1}, {8'h80, 8'h80, 1'b0}, {8'h00, 8'h00, 1'b0},
        {8'h00, 8'h20, 1'b0}, {8'hFF, 8'hFE, 1'b1}, {8'h05, 8'h04, 1'b1},
        {8'h05, 8'h05, 1'b0}
    };

    logic clk = 0, rst_n = 0, wr_en = 0, cap_in = 0, ext_clk = 0, ovf_ack = 0;
    logic [1:0] reg_sel = 0;
    logic [7:0] wr_data = 0, rd_data;
    logic tmr_out, irq_ovf, irq_match;
    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr8_multimode u0 (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .cap_in(cap_in), .ext_clk(ext_clk), .ovf_ack(ovf_ack),
        .tmr_out(tmr_out), .irq_ovf(irq_ovf), .irq_match(irq_match)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk); reg_sel = sel; wr_data = d; wr_en = 1;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] d);
        reg_sel = sel; #1 d = rd_data;
    endtask

    task automatic ext_pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ext_clk = 1; repeat (3) @(negedge clk);
            ext_clk = 0; repeat (3) @(negedge clk);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset;
        @(negedge clk); rst_n = 0; wait_cyc(3); rst_n = 1; wait_cyc(1);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        do_reset();
        // Table walk: PWM waveform under several data/count pairs (R4, R2, R6 external clock)
        foreach (PWM_TBL[k]) begin
            bus_wr(2'd1, PWM_TBL[k][16:9]);
            bus_wr(2'd0, 8'hF8);
            ext_pulse(int'(PWM_TBL[k][8:1]));
            rd(2'd2, v); check("R2 pwm count", v, PWM_TBL[k][8:1]);
            check("R4 pwm out", {7'd0, tmr_out}, {7'd0, PWM_TBL[k][0]});
        end

        // R1: reset state
        do_reset();
        rd(2'd0, v); check("R1 ctrl", v, 8'h00);
        rd(2'd2, v); check("R1 count", v, 8'h00);
        check("R1 outputs", {5'd0, tmr_out, irq_ovf, irq_match}, 8'h00);

        // R6: prescaler taps, with a clear restarting the division
        bus_wr(2'd1, 8'hFF);
        bus_wr(2'd0, 8'h28); wait_cyc(3*64);
        rd(2'd2, v); check("R6 div64", v, 8'd3);
        bus_wr(2'd0, 8'h18); wait_cyc(2*256);
        rd(2'd2, v); check("R6 div256", v, 8'd2);
        bus_wr(2'd0, 8'h08); wait_cyc(1024);
        rd(2'd2, v); check("R6 div1024", v, 8'd1);

        // R3 / R8: interval match, toggle, pending handling
        bus_wr(2'd1, 8'h03);
        bus_wr(2'd0, 8'h3A);
        ext_pulse(3);
        rd(2'd2, v); check("R3 before match", v, 8'd3);
        check("R3 out before", {7'd0, tmr_out}, 8'd0);
        ext_pulse(1);
        rd(2'd2, v); check("R3 restart", v, 8'd0);
        check("R3 toggle", {7'd0, tmr_out}, 8'd1);
        check("R8 irq_match", {7'd0, irq_match}, 8'd1);
        rd(2'd0, v); check("R3 pending set", v, 8'h33);
        ext_pulse(4);
        check("R3 second toggle", {7'd0, tmr_out}, 8'd0);
        bus_wr(2'd0, 8'h32);
        rd(2'd0, v); check("R8 write0 clears", v, 8'h32);
        check("R8 irq dropped", {7'd0, irq_match}, 8'd0);
        bus_wr(2'd0, 8'h33);
        rd(2'd0, v); check("R8 write1 no effect", v, 8'h32);

        // R5: clear command
        ext_pulse(2);
        rd(2'd2, v); check("R5 pre-clear count", v, 8'd2);
        bus_wr(2'd0, 8'h3A);
        rd(2'd2, v); check("R5 cleared", v, 8'd0);
        rd(2'd0, v); check("R5 bit3 reads 0", v, 8'h32);

        // R9: rising-edge capture, falling edge ignored
        bus_wr(2'd0, 8'h7A);
        ext_pulse(7);
        cap_in = 1; wait_cyc(4);
        rd(2'd1, v); check("R9 captured", v, 8'd7);
        rd(2'd0, v); check("R9 pending", v, 8'h73);
        bus_wr(2'd0, 8'h72);
        ext_pulse(3);
        cap_in = 0; wait_cyc(4);
        rd(2'd1, v); check("R9 fall ignored", v, 8'd7);
        rd(2'd0, v); check("R9 no pending", v, 8'h72);

        // R10: falling-edge capture, rising edge ignored
        bus_wr(2'd0, 8'hB2);
        cap_in = 1; wait_cyc(4);
        rd(2'd1, v); check("R10 rise ignored", v, 8'd7);
        ext_pulse(2);
        cap_in = 0; wait_cyc(4);
        rd(2'd1, v); check("R10 captured", v, 8'd12);
        rd(2'd0, v); check("R10 pending", v, 8'hB3);

        // R7: overflow in capture mode and acknowledge
        bus_wr(2'd0, 8'hBC);
        ext_pulse(255);
        check("R7 no ovf at FF", {7'd0, irq_ovf}, 8'd0);
        ext_pulse(1);
        rd(2'd2, v); check("R7 wrapped", v, 8'd0);
        check("R7 irq_ovf", {7'd0, irq_ovf}, 8'd1);
        @(negedge clk); ovf_ack = 1; @(negedge clk); ovf_ack = 0;
        check("R7 ack clears", {7'd0, irq_ovf}, 8'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule